// File: doc/BRIEF.md
# USB Endpoint Interrupt Generator

This block turns transaction-completion reports from a USB serial interface engine into per-endpoint interrupt requests for five endpoints. Each report arrives as a single-cycle strobe carrying the endpoint number, the transfer direction, a flag that marks the final packet of the transaction, and two handshake flags. One flag says the host acknowledged, and the other says the device acknowledged. An IN transfer completes only when the host acknowledges the data the device sent. An OUT transfer completes only when the device acknowledges data the host wrote into the endpoint buffer.

A qualified completion sets a sticky pending bit for its endpoint. Firmware clears a pending bit by pulsing a one on the matching bit of the clear vector. Each endpoint's interrupt line is its pending bit gated by its enable bit. A completion on a disabled endpoint is still recorded, so enabling the endpoint later raises its line at once.

Top module: `usb_ep_irq_gen`

## Requirements
- R1: After reset every pending bit and every interrupt line is 0.
- R2: A strobe with direction IN (evt_dir_in_i = 1), the final-packet flag set and the host-ACK flag set sets the pending bit of the addressed endpoint on the next rising clock edge.
- R3: A strobe with direction OUT (evt_dir_in_i = 0), the final-packet flag set and the device-ACK flag set sets the pending bit of the addressed endpoint on the next rising clock edge.
- R4: A strobe whose final-packet flag is 0 changes no pending bit, whatever its handshake flags are.
- R5: A final-packet strobe without the handshake matching its direction changes no pending bit. This covers IN without host ACK, even when the device-ACK flag is set, and OUT without device ACK, even when the host-ACK flag is set.
- R6: A pending bit stays set across cycles and later strobes until it is cleared.
- R7: A one on bit n of pend_clr_i clears pending bit n on the next edge. Bits of pend_clr_i that are 0 leave their pending bits unchanged.
- R8: When a qualifying strobe and a clear hit the same endpoint in the same cycle, the pending bit is set after the edge.
- R9: irq_o[n] equals pend_o[n] AND ep_en_i[n] at all times. A pending bit is recorded even while its endpoint is disabled.
- R10: A strobe with endpoint number 5, 6 or 7 changes no pending bit.
- R11: A qualifying strobe changes only the pending bit of the endpoint it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid_i | input | 1 | One-cycle strobe: a transaction report is present |
| evt_ep_i | input | 3 | Endpoint number of the report |
| evt_dir_in_i | input | 1 | 1 = IN (device to host), 0 = OUT (host to device) |
| evt_last_i | input | 1 | Report is for the final packet of the transaction |
| evt_host_ack_i | input | 1 | Host returned an ACK handshake |
| evt_dev_ack_i | input | 1 | Device sent an ACK handshake |
| ep_en_i | input | 5 | Per-endpoint interrupt enable |
| pend_clr_i | input | 5 | Write-one-to-clear strobe per pending bit |
| pend_o | output | 5 | Sticky pending bits |
| irq_o | output | 5 | Per-endpoint interrupt request lines |

## Verification
The bench crosses each direction with the other side's handshake. A design that checked any ACK, instead of the ACK that belongs to the direction, would set pending on an IN transfer acknowledged only by the device. It drives a completion and a clear onto one endpoint in the same cycle, where a clear-priority design would lose the event. It sends reports for endpoints 5 to 7, where a decoder that truncated or wrapped the number would set a real bit. It completes transfers while interrupts are disabled and then enables them, which exposes a design that gated the recording instead of the output.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;

    localparam int unsigned DEF_NUM_EP = 5;

    typedef enum logic {
        XFER_OUT = 1'b0,
        XFER_IN  = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic pend;
    } pend_state_t;

endpackage

// File: rtl/usb_ep_evt_qualify.sv
module usb_ep_evt_qualify
    import usb_ep_irq_pkg::*;
#(
    parameter int unsigned NUM_EP = DEF_NUM_EP,
    parameter int unsigned EP_W   = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [EP_W-1:0]   ep_i,
    input  logic              dir_in_i,
    input  logic              last_i,
    input  logic              host_ack_i,
    input  logic              dev_ack_i,
    output logic [NUM_EP-1:0] hit_o
);

    xfer_dir_e dir;
    logic      hs_ok;
    logic      in_range;
    logic      qual;

    always_comb begin
        dir      = xfer_dir_e'(dir_in_i);
        hs_ok    = (dir == XFER_IN) ? host_ack_i : dev_ack_i;
        in_range = (32'(ep_i) < NUM_EP);
        qual     = valid_i && last_i && hs_ok && in_range;
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_dec
        assign hit_o[g] = qual && (ep_i == EP_W'(g));
    end

    // R11: a report addresses at most one endpoint
    p_single_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o));

    // R10: numbers past the last endpoint reach no endpoint
    p_out_of_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && 32'(ep_i) >= NUM_EP) |-> (hit_o == '0));

    // R4: intermediate packets never qualify
    p_mid_packet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!last_i) |-> (hit_o == '0));

    // R5: IN needs the host's ACK
    p_in_needs_host_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dir_in_i && !host_ack_i) |-> (hit_o == '0));

    // R5: OUT needs the device's ACK
    p_out_needs_dev_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !dir_in_i && !dev_ack_i) |-> (hit_o == '0));

endmodule

// File: rtl/usb_ep_pend_cell.sv
module usb_ep_pend_cell
    import usb_ep_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic pend_o,
    output logic irq_o
);

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.pend = 1'b0;
        end
        if (set_i) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign irq_o  = st_q.pend & en_i;

    // R8: a set beats a simultaneous clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

    // R6: pending holds without a clear
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);

    // R7: a clear with no new event drops the bit
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);

    // R9: no request without an enable
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> en_i);

endmodule

// File: rtl/usb_ep_irq_gen.sv
module usb_ep_irq_gen
    import usb_ep_irq_pkg::*;
#(
    parameter int unsigned NUM_EP = DEF_NUM_EP,
    parameter int unsigned EP_W   = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid_i,
    input  logic [EP_W-1:0]   evt_ep_i,
    input  logic              evt_dir_in_i,
    input  logic              evt_last_i,
    input  logic              evt_host_ack_i,
    input  logic              evt_dev_ack_i,
    input  logic [NUM_EP-1:0] ep_en_i,
    input  logic [NUM_EP-1:0] pend_clr_i,
    output logic [NUM_EP-1:0] pend_o,
    output logic [NUM_EP-1:0] irq_o
);

    logic [NUM_EP-1:0] hit;

    usb_ep_evt_qualify #(
        .NUM_EP (NUM_EP),
        .EP_W   (EP_W)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (evt_valid_i),
        .ep_i       (evt_ep_i),
        .dir_in_i   (evt_dir_in_i),
        .last_i     (evt_last_i),
        .host_ack_i (evt_host_ack_i),
        .dev_ack_i  (evt_dev_ack_i),
        .hit_o      (hit)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        usb_ep_pend_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (hit[g]),
            .clr_i  (pend_clr_i[g]),
            .en_i   (ep_en_i[g]),
            .pend_o (pend_o[g]),
            .irq_o  (irq_o[g])
        );
    end

    // R4, R5, R10: a pending bit rises only after a qualified report
    p_no_spontaneous_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |=> ((pend_o & ~$past(pend_o)) == '0));

    // R11: a report raises no bit other than its own
    p_only_target_rises_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(hit)) == '0));

endmodule

// File: tb/usb_ep_irq_gen_tb.sv
module usb_ep_irq_gen_tb_top;

    localparam int NEP = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           evt_valid = 1'b0;
    logic [2:0]     evt_ep = '0;
    logic           evt_dir_in = 1'b0;
    logic           evt_last = 1'b0;
    logic           evt_hack = 1'b0;
    logic           evt_dack = 1'b0;
    logic [NEP-1:0] en = '0;
    logic [NEP-1:0] clr = '0;
    logic [NEP-1:0] pend;
    logic [NEP-1:0] irq;

    logic [NEP-1:0] m_pend = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usb_ep_irq_gen dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_valid_i    (evt_valid),
        .evt_ep_i       (evt_ep),
        .evt_dir_in_i   (evt_dir_in),
        .evt_last_i     (evt_last),
        .evt_host_ack_i (evt_hack),
        .evt_dev_ack_i  (evt_dack),
        .ep_en_i        (en),
        .pend_clr_i     (clr),
        .pend_o         (pend),
        .irq_o          (irq)
    );

    function automatic logic [NEP-1:0] exp_hit(logic v, logic [2:0] ep, logic din,
                                               logic last, logic hack, logic dack);
        logic ok;
        ok = din ? hack : dack;
        if (v && last && ok && ep < 3'd5) return NEP'(1) << ep;
        return '0;
    endfunction

    task automatic chk(string req, logic [NEP-1:0] act, logic [NEP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(logic v, logic [2:0] ep, logic din, logic last,
                        logic hack, logic dack, logic [NEP-1:0] e, logic [NEP-1:0] c);
        @(negedge clk);
        evt_valid = v; evt_ep = ep; evt_dir_in = din; evt_last = last;
        evt_hack = hack; evt_dack = dack; en = e; clr = c;
        m_pend = (m_pend & ~c) | exp_hit(v, ep, din, last, hack, dack);
        @(posedge clk);
        #1;
    endtask

    task automatic idle(logic [NEP-1:0] e);
        step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, e, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pend after reset", pend, '0);
        chk("R1 irq after reset", irq, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: IN, last, host ACK on ep 2
        step(1, 3'd2, 1, 1, 1, 0, '1, '0);
        chk("R2 IN host ack", pend, 5'b00100);
        chk("R9 irq follows enabled pend", irq, 5'b00100);
        // R3: OUT, last, device ACK on ep 4
        step(1, 3'd4, 0, 1, 0, 1, '1, '0);
        chk("R3 OUT dev ack", pend, 5'b10100);
        // R7: clear ep 2 only
        step(0, 3'd0, 0, 0, 0, 0, '1, 5'b00100);
        chk("R7 w1c single bit", pend, 5'b10000);
        step(0, 3'd0, 0, 0, 0, 0, '1, 5'b10000);
        chk("R7 w1c second bit", pend, 5'b00000);
        // R4: not last
        step(1, 3'd1, 1, 0, 1, 1, '1, '0);
        chk("R4 intermediate packet", pend, '0);
        // R5: IN with device ack only
        step(1, 3'd1, 1, 1, 0, 1, '1, '0);
        chk("R5 IN without host ack", pend, '0);
        // R5: OUT with host ack only
        step(1, 3'd3, 0, 1, 1, 0, '1, '0);
        chk("R5 OUT without dev ack", pend, '0);
        // R10: out-of-range endpoints
        for (int k = 5; k < 8; k++) begin
            step(1, 3'(k), 1, 1, 1, 1, '1, '0);
            chk("R10 endpoint >= 5 ignored", pend, '0);
        end
        // R9: disabled endpoint still records
        step(1, 3'd0, 0, 1, 0, 1, '0, '0);
        chk("R9 pend while disabled", pend, 5'b00001);
        chk("R9 irq masked", irq, '0);
        // R6: holds across idle cycles and other events
        idle('0);
        idle('0);
        step(1, 3'd3, 1, 1, 1, 0, '0, '0);
        chk("R6 sticky and R11 independent", pend, 5'b01001);
        @(negedge clk);
        en = 5'b00001;
        #1;
        chk("R9 enable raises irq", irq, 5'b00001);
        // R8: event and clear same ep same cycle
        step(1, 3'd3, 1, 1, 1, 0, 5'b00001, 5'b01001);
        chk("R8 set wins over clear", pend, 5'b01000);
        step(0, 3'd0, 0, 0, 0, 0, '0, '1);
        chk("R7 clear all", pend, '0);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[4:2], r[5], r[6] | r[7], r[8], r[9], r[14:10],
                 (r[17:15] == 3'd0) ? r[22:18] : '0);
            chk("R2 R3 R6 R11 random pend", pend, m_pend);
            chk("R9 random irq", irq, m_pend & en);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule